// File: doc/BRIEF.md
# Edge-Multiplied Correction Clock Generator

This block turns a slow external reference edge into a dense stream of count-enable pulses for downstream timers. A correction counter runs on the system clock and steps forward by one, emitting one multiplied-clock pulse per step, only while its value is strictly below a target value supplied by the host. The host recomputes the target as the reference period is measured, so the pulse stream follows the reference rate.

A clear value sets the point where counting stops. When a step lands on the clear value, the block issues a one-cycle clear strobe to every downstream counter whose enable bit is set. On each reference edge the counter is rewound to one. If it has not yet reached the clear value, it first catches up to the clear value, pulsing once per step and ignoring the target, so that downstream counters always see the full count for every reference period. A reference edge that arrives while a companion counter reads zero is an initialization. The counter is loaded with one at once, and no catch-up takes place.

Top module: `corr_clk_gen`

## Requirements
- R1: Outside catch-up, the counter advances by exactly one in a cycle only while its value is strictly below `target` and not equal to `clr_val`. Each advance raises `mul_pulse` for one cycle, in the same cycle that `corr_count` shows the new value.
- R2: Outside catch-up, while the counter is at or above `target`, it holds its value and `mul_pulse` stays low, even when `target` is lowered below the current count.
- R3: Outside catch-up, when the counter equals `clr_val`, it stops, whatever the value of `target`.
- R4: A reference edge that arrives while the counter equals `clr_val` loads the counter with 1 and produces no pulse.
- R5: A reference edge that arrives while the counter differs from `clr_val` (with `zero_in` low) starts catch-up. The counter steps once per cycle, ignoring `target`, with one pulse per step, until it equals `clr_val`. It is then loaded with 1, and normal counting resumes.
- R6: A reference edge that arrives while `zero_in` is high loads the counter with 1 at once. No catch-up and no clear strobe take place.
- R7: A step that lands on `clr_val` raises `clr_strobe[i]` for one cycle for each bit `i` where `clr_en[i]` is 1. A bit whose enable is 0 never pulses.
- R8: Synchronous reset sets the counter to 1 and drives `mul_pulse` and all `clr_strobe` bits low.
- R9: `ref_in` passes through a two-flop synchronizer. Each rising transition counts as exactly one edge event, however long the input stays high. Reference edges that arrive during catch-up are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous reference edge input |
| zero_in | input | 1 | High while the companion counter reads zero |
| target | input | 16 | Target value that gates counting |
| clr_val | input | 16 | Clear value at which counting stops |
| clr_en | input | 4 | Per-downstream-counter clear strobe enables |
| mul_pulse | output | 1 | Multiplied-clock pulse, one per counter step |
| clr_strobe | output | 4 | One-cycle clear strobes to downstream counters |
| corr_count | output | 16 | Current correction counter value |

## Verification
The hardest situation to reach is catch-up. It needs the counter parked strictly between the target and the clear value, and then an edge that must ignore the target for several steps before the rewind. The stimulus first lets the counter settle at a swept target below a swept clear value. It then fires an edge and holds `ref_in` high for a long time. The total pulse count must equal the catch-up distance plus the recount to the target, which exposes both a missed catch-up and any retriggering.

// File: rtl/corr_clk_pkg.sv
package corr_clk_pkg;

    parameter int CW = 16;
    parameter int NSTB = 4;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_CATCH = 1'b1
    } corr_state_e;

    typedef struct packed {
        logic [CW-1:0] count;
        logic          pulse;
        logic          land;
    } corr_step_t;

    function automatic logic [CW-1:0] one_val();
        return {{(CW-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/corr_edge_sync.sv
module corr_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic edge_pulse
);
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= 3'b000;
        else     sh <= {sh[1:0], async_in};
    end

    assign edge_pulse = sh[1] & ~sh[2];

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        edge_pulse |=> !edge_pulse); // R9
endmodule

// File: rtl/corr_core.sv
module corr_core
    import corr_clk_pkg::*;
#(
    parameter int W = CW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ref_edge,
    input  logic         zero_in,
    input  logic [W-1:0] target,
    input  logic [W-1:0] clr_val,
    output logic [W-1:0] count,
    output logic         pulse_q,
    output logic         land_q
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    corr_state_e st, st_n;
    logic [W-1:0] nxt;
    logic         step;
    logic         land;

    always_comb begin
        nxt  = count;
        st_n = st;
        step = 1'b0;
        unique case (st)
            ST_RUN: begin
                if (ref_edge) begin
                    if (zero_in || count == clr_val) nxt = ONE;
                    else                             st_n = ST_CATCH;
                end else if (count < target && count != clr_val) begin
                    step = 1'b1;
                end
            end
            ST_CATCH: begin
                if (count == clr_val) begin
                    nxt  = ONE;
                    st_n = ST_RUN;
                end else begin
                    step = 1'b1;
                end
            end
            default: st_n = ST_RUN;
        endcase
        if (step) nxt = count + ONE;
        land = step && ((count + ONE) == clr_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_RUN;
            count   <= ONE;
            pulse_q <= 1'b0;
            land_q  <= 1'b0;
        end else begin
            st      <= st_n;
            count   <= nxt;
            pulse_q <= step;
            land_q  <= land;
        end
    end

    AST_PULSE_STEP: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> count == $past(count) + ONE); // R1
    AST_HOLD_AT_TARGET: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && !ref_edge && count >= target) |=> (!pulse_q && $stable(count))); // R2
    AST_STOP_AT_CLR: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && !ref_edge && count == clr_val) |=> $stable(count)); // R3
    AST_EDGE_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && ref_edge && (zero_in || count == clr_val)) |=> (count == ONE && !pulse_q)); // R4
    AST_CATCH_STEPS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CATCH && count != clr_val) |=> pulse_q); // R5
endmodule

// File: rtl/corr_strobe.sv
module corr_strobe #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         land,
    input  logic [N-1:0] en,
    output logic [N-1:0] strobe
);
    for (genvar i = 0; i < N; i++) begin : g_stb
        always_ff @(posedge clk) begin
            if (rst) strobe[i] <= 1'b0;
            else     strobe[i] <= land & en[i];
        end
    end

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (strobe != '0) |=> (strobe == '0)); // R7
endmodule

// File: rtl/corr_clk_gen.sv
module corr_clk_gen
    import corr_clk_pkg::*;
#(
    parameter int W = CW,
    parameter int N = NSTB
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ref_in,
    input  logic         zero_in,
    input  logic [W-1:0] target,
    input  logic [W-1:0] clr_val,
    input  logic [N-1:0] clr_en,
    output logic         mul_pulse,
    output logic [N-1:0] clr_strobe,
    output logic [W-1:0] corr_count
);
    logic ref_edge;
    logic land_q;

    corr_edge_sync u_sync (
        .clk(clk), .rst(rst), .async_in(ref_in), .edge_pulse(ref_edge)
    );

    corr_core #(.W(W)) u_core (
        .clk(clk), .rst(rst), .ref_edge(ref_edge), .zero_in(zero_in),
        .target(target), .clr_val(clr_val), .count(corr_count),
        .pulse_q(mul_pulse), .land_q(land_q)
    );

    logic land_d;
    always_ff @(posedge clk) begin
        if (rst) land_d <= 1'b0;
        else     land_d <= land_q;
    end

    corr_strobe #(.N(N)) u_stb (
        .clk(clk), .rst(rst), .land(land_q), .en(clr_en), .strobe(land_unused_guard)
    );

    logic [N-1:0] land_unused_guard;
    assign clr_strobe = land_unused_guard;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (corr_count == {{(W-1){1'b0}}, 1'b1} && !mul_pulse && clr_strobe == '0)); // R8
    AST_STROBE_AT_CLR: assert property (@(posedge clk) disable iff (rst)
        (land_q && !land_d) |-> corr_count == $past(clr_val)); // R7
endmodule

// File: tb/sim_corr_clk_gen.sv
module sim_corr_clk_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_in = 1'b0;
    logic        zero_in = 1'b0;
    logic [15:0] target = 16'd0;
    logic [15:0] clr_val = 16'd0;
    logic [3:0]  clr_en = 4'd0;
    logic        mul_pulse;
    logic [3:0]  clr_strobe;
    logic [15:0] corr_count;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    int stb [4];
    bit done = 1'b0;

    always #4 clk = ~clk;

    corr_clk_gen u0 (
        .clk(clk), .rst(rst), .ref_in(ref_in), .zero_in(zero_in),
        .target(target), .clr_val(clr_val), .clr_en(clr_en),
        .mul_pulse(mul_pulse), .clr_strobe(clr_strobe), .corr_count(corr_count)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (mul_pulse) pulses++;
            for (int i = 0; i < 4; i++) if (clr_strobe[i]) stb[i]++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_counts();
        pulses = 0;
        for (int i = 0; i < 4; i++) stb[i] = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ref_in = 1'b0;
        cycles(4);
        rst = 1'b0;
        clear_counts();
    endtask

    task automatic fire_edge(input int hold);
        @(negedge clk);
        ref_in = 1'b1;
        cycles(hold);
        ref_in = 1'b0;
        cycles(4);
    endtask

    initial begin
        do_reset();
        // R8: reset state
        chk("R8 count", corr_count, 1);
        chk("R8 pulse", mul_pulse, 0);
        chk("R8 strobe", clr_strobe, 0);

        // R1/R2: sweep of target values
        for (int t = 1; t <= 24; t++) begin
            target = t[15:0];
            clr_val = 16'd200;
            do_reset();
            cycles(40);
            chk("R1 count at target", corr_count, t);
            chk("R1 pulses", pulses, t - 1);
        end

        // R2: lowering the target below the count holds it
        target = 16'd10; clr_val = 16'd200;
        do_reset();
        cycles(20);
        clear_counts();
        target = 16'd4;
        cycles(20);
        chk("R2 hold count", corr_count, 10);
        chk("R2 no pulse", pulses, 0);

        // R3/R7: stop at the clear value, strobe per enable mask
        for (int c = 2; c <= 20; c++) begin
            target = 16'd300;
            clr_val = c[15:0];
            clr_en = c[3:0];
            do_reset();
            cycles(40);
            chk("R3 stop at clr", corr_count, c);
            chk("R3 pulses", pulses, c - 1);
            for (int i = 0; i < 4; i++) chk("R7 strobe mask", stb[i], (c >> i) & 1);
        end

        // R4: edge while at the clear value reloads 1
        target = 16'd300; clr_val = 16'd9; clr_en = 4'hF;
        do_reset();
        cycles(20);
        target = 16'd1;
        clear_counts();
        fire_edge(4);
        cycles(10);
        chk("R4 reload one", corr_count, 1);
        chk("R4 no pulse", pulses, 0);

        // R5/R9: catch-up, reference held high for a long time
        for (int t = 2; t <= 6; t++) begin
            for (int d = 3; d <= 7; d++) begin
                target = t[15:0];
                clr_val = 16'(t + d);
                clr_en = 4'b0101;
                zero_in = 1'b0;
                do_reset();
                cycles(20);
                clear_counts();
                fire_edge(100);
                cycles(30);
                chk("R5 count after catch-up", corr_count, t);
                chk("R5 R9 pulses", pulses, d + t - 1);
                chk("R7 strobe en", stb[0], 1);
                chk("R7 strobe dis", stb[1], 0);
            end
        end

        // R6: edge with companion zero loads 1 without catch-up
        target = 16'd8; clr_val = 16'd50; clr_en = 4'hF;
        do_reset();
        cycles(20);
        clear_counts();
        zero_in = 1'b1;
        fire_edge(4);
        zero_in = 1'b0;
        cycles(20);
        chk("R6 count", corr_count, 8);
        chk("R6 pulses", pulses, 7);
        chk("R6 no strobe", stb[3], 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule